// File: doc/BRIEF.md
# Power-on reset release controller

This block generates the internal system reset for a low-power controller clocked by a 32.768 kHz oscillator. There are two sources of a reset request. The first is an active-low external reset pin. The second is optional and fires when all four key inputs are held low together; a build-time parameter turns it on or off. Every input is asynchronous. Each one passes through a two-flop synchroniser and then a filter that counts consecutive low samples, so short noise spikes do not cause a reset.

A filtered request sets a set-dominant latch, and the latch output is the internal reset. The latch does not clear after a fixed count. It clears on the first clock edge at which the request is gone and the 2 Hz tap of a free-running divider is high. The release delay therefore depends on the divider phase. With the default 15-bit divider it can reach a quarter of a second.

The divider also brings out a 1 Hz tap. Only the hard power-up reset `rst_ni` clears the divider; the internal reset never does. The hard power-up reset leaves the latch set, so the system stays in reset until the first valid release.

Top module: `por_release_ctrl`

## Requirements
- R1: While `rst_ni` is low, `sys_rst_o` is 1 and both tick outputs are 0.
- R2: After `rst_ni` rises, `sys_rst_o` stays 1 until the first rising edge at which the 2 Hz tap was already high. With the defaults, it is still 1 after edge 8192 and is 0 after edge 8193, counting edges from the release of `rst_ni`.
- R3: If `reset_pin_ni` is sampled low on 3 or more consecutive edges, `sys_rst_o` goes to 1. This happens on the sixth rising edge counted from the first edge that samples the pin low.
- R4: A low pulse on `reset_pin_ni` that is sampled on 2 edges or fewer has no effect on `sys_rst_o`.
- R5: After the request ends, `sys_rst_o` clears on the first edge at which the request is inactive and the 2 Hz tap was high. If the tap is low at that point, the release waits for the tap to rise, which can take up to 2^(DIV_W-2) cycles.
- R6: Set has priority over release. While the filtered request is active, `sys_rst_o` stays 1 even when the 2 Hz tap is high.
- R7: The divider counts up by one on each edge, starting from 0 when `rst_ni` is released. `tick_2hz_o` is counter bit DIV_W-2 and `tick_1hz_o` is counter bit DIV_W-1.
- R8: With `KEY_RESET_EN` = 1, all four `key_ni` bits low together for 3 or more samples asserts `sys_rst_o` with the same timing as the pin. If three or fewer of the keys are low, there is no effect.
- R9: With `KEY_RESET_EN` = 0, `key_ni` has no effect on `sys_rst_o`.
- R10: The internal reset does not disturb the divider: the taps keep the phase they had from the release of `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32.768 kHz oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| reset_pin_ni | input | 1 | External active-low reset request, asynchronous |
| key_ni | input | KEY_N | Key inputs; all low together requests a reset |
| sys_rst_o | output | 1 | Internal system reset, active high, registered |
| tick_2hz_o | output | 1 | 2 Hz divider tap |
| tick_1hz_o | output | 1 | 1 Hz divider tap |

## Verification
The hardest case to reach is a release that has to wait for the 2 Hz tap after the request is already gone. That window exists only while the tap is low, and from the ports it can only be reached by letting the free-running divider advance to a known phase. The bench counts edges from the release of `rst_ni`. It places a pulse in the half-period where the tap is low, then expects the release on the exact edge after the tap rises, some eight thousand cycles later. Short pulses, a long pulse held while the tap is high, and key patterns are placed at fixed cycles inside the high half-period, so each expected edge is known in advance.

// File: rtl/por_pkg.sv
package por_pkg;
  localparam int unsigned DIV_W_DEF    = 15;
  localparam int unsigned SYNC_DEF     = 2;
  localparam int unsigned FILT_LEN_DEF = 3;
  localparam int unsigned KEY_N_DEF    = 4;

  typedef struct packed {
    logic hz1;
    logic hz2;
  } por_taps_t;
endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] nxt;
    if (s == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_rest
      assign nxt = stg_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= {W{RST_VAL}};
      else         stg_q[s] <= nxt;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/por_glitch_filter.sv
module por_glitch_filter #(
  parameter int unsigned LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  output logic req_o
);
  localparam int unsigned CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(LEN);

  logic [CW-1:0] run_q;

  // count consecutive low samples, saturate at LEN
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (!low_i)     run_q <= '0;
    else if (run_q != FULL) run_q <= run_q + 1'b1;
  end

  assign req_o = (run_q == FULL);
endmodule

// File: rtl/por_divider.sv
module por_divider #(
  parameter int unsigned W = 15
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output por_pkg::por_taps_t taps_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign taps_o.hz1 = cnt_q[W-1];
  assign taps_o.hz2 = cnt_q[W-2];
endmodule

// File: rtl/por_release_ctrl.sv
module por_release_ctrl #(
  parameter int unsigned DIV_W        = por_pkg::DIV_W_DEF,
  parameter int unsigned SYNC_STAGES  = por_pkg::SYNC_DEF,
  parameter int unsigned FILT_LEN     = por_pkg::FILT_LEN_DEF,
  parameter int unsigned KEY_N        = por_pkg::KEY_N_DEF,
  parameter bit          KEY_RESET_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_pin_ni,
  input  logic [KEY_N-1:0] key_ni,
  output logic             sys_rst_o,
  output logic             tick_2hz_o,
  output logic             tick_1hz_o
);
  localparam int unsigned IN_W = KEY_N + 1;

  logic [IN_W-1:0]    raw_in, sync_in;
  logic               pin_sync;
  logic [KEY_N-1:0]   key_sync;
  logic               key_low, src_low, filt_req;
  logic               rst_latch_q;
  por_pkg::por_taps_t taps;

  assign raw_in = {key_ni, reset_pin_ni};

  por_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(raw_in), .q_o(sync_in)
  );

  assign pin_sync = sync_in[0];
  assign key_sync = sync_in[IN_W-1:1];
  assign key_low  = KEY_RESET_EN && (key_sync == '0);
  assign src_low  = !pin_sync || key_low;

  por_glitch_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i, .rst_ni, .low_i(src_low), .req_o(filt_req)
  );

  por_divider #(.W(DIV_W)) u_div (
    .clk_i, .rst_ni, .taps_o(taps)
  );

  // set-dominant latch; power-up leaves it set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rst_latch_q <= 1'b1;
    else if (filt_req) rst_latch_q <= 1'b1;
    else if (taps.hz2) rst_latch_q <= 1'b0;
  end

  assign sys_rst_o  = rst_latch_q;
  assign tick_2hz_o = taps.hz2;
  assign tick_1hz_o = taps.hz1;
endmodule

// File: rtl/por_release_ctrl_chk.sv
module por_release_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic src_low_i,
  input logic req_i,
  input logic sys_rst_i,
  input logic tick_2hz_i,
  input logic tick_1hz_i
);
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      assert_held_in_reset_R1: assert (sys_rst_i && !tick_2hz_i && !tick_1hz_i);
    end
  end

  assert_set_on_request_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_i) |-> $past(req_i));

  assert_filter_needs_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_i) |-> $past(src_low_i));

  assert_release_on_tap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_rst_i) |-> ($past(tick_2hz_i) && !$past(req_i)));

  assert_set_priority_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> sys_rst_i);

  assert_tap_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tick_1hz_i) |-> $fell(tick_2hz_i));
endmodule

bind por_release_ctrl por_release_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_low_i  (src_low),
  .req_i      (filt_req),
  .sys_rst_i  (sys_rst_o),
  .tick_2hz_i (tick_2hz_o),
  .tick_1hz_i (tick_1hz_o)
);

// File: tb/por_release_ctrl_bench.sv
`timescale 1ns/1ps
module por_release_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n   = 1'b0;
  logic       pin_n   = 1'b1;
  logic       pin_b_n = 1'b1;
  logic [3:0] key_n   = 4'hF;
  logic       rst_a, t2_a, t1_a, rst_b, t2_b, t1_b;

  int checks = 0;
  int errors = 0;
  int cyc;
  bit done = 1'b0;

  por_release_ctrl u_por_release_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .reset_pin_ni(pin_n), .key_ni(key_n),
    .sys_rst_o(rst_a), .tick_2hz_o(t2_a), .tick_1hz_o(t1_a)
  );

  por_release_ctrl #(.KEY_RESET_EN(1'b0)) u_nokey (
    .clk_i(clk), .rst_ni(rst_n), .reset_pin_ni(pin_b_n), .key_ni(key_n),
    .sys_rst_o(rst_b), .tick_2hz_o(t2_b), .tick_1hz_o(t1_b)
  );

  // sel: 0 sys_rst, 1 2Hz tap, 2 1Hz tap, 3 sys_rst of key-disabled instance
  typedef struct {
    int    at;
    int    sel;
    logic  exp;
    string tag;
  } item_t;
  item_t sb_q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d act=%b exp=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic push(int at, int sel, logic exp, string tag);
    sb_q.push_back('{at, sel, exp, tag});
  endtask

  function automatic logic pick(int sel);
    case (sel)
      0:       return rst_a;
      1:       return t2_a;
      2:       return t1_a;
      default: return rst_b;
    endcase
  endfunction

  // monitor: compare at the negedge after the target edge
  always @(negedge clk) begin
    if (rst_n) begin
      while (sb_q.size() > 0 && sb_q[0].at == cyc) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, pick(it.sel), it.exp);
      end
    end
  end

  // mode: 0 pin, 1 all keys, 2 three keys
  task automatic drive_low(int c, int p, int mode);
    while (cyc != c) @(negedge clk);
    case (mode)
      0:       pin_n = 1'b0;
      1:       key_n = 4'h0;
      default: key_n = 4'h8;
    endcase
    repeat (p) @(negedge clk);
    pin_n = 1'b1;
    key_n = 4'hF;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    // power-up release R2, taps R7
    push(8191, 1, 1'b0, "R7 2hz low");
    push(8192, 0, 1'b1, "R2 held");
    push(8192, 1, 1'b1, "R7 2hz high");
    push(8193, 0, 1'b0, "R2 release");
    push(8193, 3, 1'b0, "R2 release nokey");
    // 2-cycle glitch R4
    push(9004, 0, 1'b0, "R4 glitch");
    push(9008, 0, 1'b0, "R4 glitch");
    // 3-cycle pulse, tap high R3
    push(9105, 0, 1'b0, "R3 latency");
    push(9106, 0, 1'b1, "R3 set");
    push(9107, 0, 1'b0, "R5 quick release");
    // long pulse R6
    push(9206, 0, 1'b1, "R6 prio");
    push(9215, 0, 1'b1, "R6 prio");
    push(9223, 0, 1'b1, "R6 prio");
    push(9224, 0, 1'b0, "R6 release");
    // all keys R8/R9
    push(9306, 0, 1'b1, "R8 keys set");
    push(9306, 3, 1'b0, "R9 keys off");
    push(9307, 0, 1'b1, "R8 keys held");
    push(9308, 0, 1'b0, "R8 keys release");
    push(9310, 3, 1'b0, "R9 keys off");
    // three keys R8
    push(9410, 0, 1'b0, "R8 three keys");
    push(9425, 0, 1'b0, "R8 three keys");
    push(16384, 1, 1'b0, "R7 2hz");
    push(16384, 2, 1'b1, "R7 1hz");
    // pulse while tap low R5
    push(16406, 0, 1'b1, "R5 set");
    push(20000, 0, 1'b1, "R5 wait tap");
    push(24576, 0, 1'b1, "R5 wait tap");
    push(24576, 1, 1'b1, "R10 2hz phase");
    push(24576, 2, 1'b1, "R10 1hz phase");
    push(24577, 0, 1'b0, "R5 release");

    repeat (3) @(negedge clk);
    check("R1 rst", rst_a, 1'b1);
    check("R1 2hz", t2_a, 1'b0);
    check("R1 1hz", t1_a, 1'b0);
    check("R1 rst nokey", rst_b, 1'b1);
    rst_n = 1'b1;

    drive_low(9000, 2, 0);
    drive_low(9100, 3, 0);
    drive_low(9200, 20, 0);
    drive_low(9300, 4, 1);
    drive_low(9400, 30, 2);
    drive_low(16400, 5, 0);

    while (sb_q.size() > 0) @(negedge clk);
    done = 1'b1;
    summary();
  end

  initial begin
    #(4 * 40000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R5 act=pending%0d exp=0", sb_q.size());
      summary();
    end
  end
endmodule